// File: doc/BRIEF.md
# Dispatch Admission and Station Routing

This block sits at the head of an out-of-order dispatch queue. In each cycle it looks at the instruction waiting at the head and decides whether that instruction may leave the queue. An instruction leaves only when three resources all have room: a reorder buffer entry, a slot in the reservation station that serves its execution class, and, if the instruction writes a register, a free rename register. When it is admitted, the block raises a one-hot select toward the correct reservation station and passes the instruction's reorder buffer tag along with it.

The resources are checked in a fixed order: reorder buffer, then station, then rename file. When an instruction is held back, only the first resource that blocks it is charged for the stall. Each resource has a saturating stall counter. Logical and integer instructions share one station. No-op instructions need no station. An undefined class code is handled like a no-op, but it also raises an error flag.

Top module: `dsp_admit`

## Requirements
- R1: `adm_go` is high exactly when `hd_valid` is high and none of the three resource checks blocks.
- R2: While `hd_valid` and `rob_full` are both high, `adm_go` is low. The next cycle, `cnt_rob` has risen by one and `cnt_stn` and `cnt_ren` are unchanged, whatever the other inputs are.
- R3: With the reorder buffer not full, an instruction whose station bit in `stn_full` is set is refused. The next cycle, only `cnt_stn` has risen.
- R4: With the first two checks passing, an instruction with `hd_dst` high is refused when `ren_free` is low. The next cycle, only `cnt_ren` has risen.
- R5: When `hd_dst` is low, `ren_free` has no effect on `adm_go` or on any counter.
- R6: The station index is 0 for class codes 0 (logical) and 1 (integer), 1 for code 2 (floating-point), 2 for code 3 (memory), 3 for code 4 (multiply/divide) and 4 for code 5 (branch). Bit i of `stn_full` and of `stn_sel` refers to station i.
- R7: Class code 6 (no-op) ignores every bit of `stn_full`. When it is admitted, `stn_sel` is zero.
- R8: Class code 7 raises `cls_err` while `hd_valid` is high. It skips the station check in the same way as a no-op and never selects a station.
- R9: `stn_sel` is zero whenever `adm_go` is low. When `adm_go` is high, `stn_sel` has the bit of the station from R6 set, or is zero under R7 and R8. `stn_tag` always equals `hd_tag`.
- R10: Each counter stops at its largest value (all ones). No counter changes while `hd_valid` is low.
- R11: After reset, all three counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hd_valid | input | 1 | An instruction is waiting at the queue head |
| hd_cls | input | 3 | Execution class code of the head instruction |
| hd_dst | input | 1 | The head instruction writes a destination register |
| hd_tag | input | TAG_W | Reorder buffer tag of the head instruction |
| rob_full | input | 1 | The reorder buffer has no free entry |
| stn_full | input | N_STN | One full flag per reservation station |
| ren_free | input | 1 | The rename file has a free entry |
| adm_go | output | 1 | The head instruction is dispatched this cycle |
| stn_sel | output | N_STN | One-hot select of the receiving station |
| stn_tag | output | TAG_W | Reorder buffer tag forwarded to the station |
| cls_err | output | 1 | The head class code is undefined |
| cnt_rob | output | CNT_W | Stalls charged to the reorder buffer |
| cnt_stn | output | CNT_W | Stalls charged to the reservation stations |
| cnt_ren | output | CNT_W | Stalls charged to the rename file |

## Verification
The bench builds the block with CNT_W set to 3, so each counter reaches its ceiling of 7 after a handful of stalls. This lets the run check both the saturation of R10 and the one-counter-per-cycle rule, and check them again after the counters have stopped moving. TAG_W is 5 so that tag forwarding can be seen with varied values. All eight class codes are driven against random full-flag patterns, which covers every priority combination.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
    localparam int N_STN = 5;

    typedef enum logic [2:0] {
        CLS_LOGIC = 3'd0,
        CLS_INT   = 3'd1,
        CLS_FP    = 3'd2,
        CLS_MEM   = 3'd3,
        CLS_MDV   = 3'd4,
        CLS_BR    = 3'd5,
        CLS_NOP   = 3'd6,
        CLS_BAD   = 3'd7
    } cls_e;

    typedef enum logic [1:0] {
        VD_GO  = 2'd0,
        VD_ROB = 2'd1,
        VD_STN = 2'd2,
        VD_REN = 2'd3
    } verdict_e;
endpackage

// File: rtl/dsp_route.sv
module dsp_route
    import dsp_pkg::*;
(
    input  logic [2:0]       cls,
    output logic [N_STN-1:0] want,
    output logic             bad
);
    always_comb begin
        want = '0;
        bad  = 1'b0;
        unique case (cls_e'(cls))
            CLS_LOGIC, CLS_INT: want[0] = 1'b1;
            CLS_FP:             want[1] = 1'b1;
            CLS_MEM:            want[2] = 1'b1;
            CLS_MDV:            want[3] = 1'b1;
            CLS_BR:             want[4] = 1'b1;
            CLS_NOP:            want    = '0;
            CLS_BAD:            bad     = 1'b1;
        endcase
    end
endmodule

// File: rtl/dsp_judge.sv
module dsp_judge
    import dsp_pkg::*;
(
    input  logic             rob_full,
    input  logic [N_STN-1:0] want,
    input  logic [N_STN-1:0] stn_full,
    input  logic             dst,
    input  logic             ren_free,
    output verdict_e         vd
);
    always_comb begin
        if (rob_full)
            vd = VD_ROB;
        else if (|(want & stn_full))
            vd = VD_STN;
        else if (dst && !ren_free)
            vd = VD_REN;
        else
            vd = VD_GO;
    end
endmodule

// File: rtl/dsp_stall_ctr.sv
module dsp_stall_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (inc && cnt != TOP)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dsp_admit.sv
module dsp_admit
    import dsp_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hd_valid,
    input  logic [2:0]       hd_cls,
    input  logic             hd_dst,
    input  logic [TAG_W-1:0] hd_tag,
    input  logic             rob_full,
    input  logic [N_STN-1:0] stn_full,
    input  logic             ren_free,
    output logic             adm_go,
    output logic [N_STN-1:0] stn_sel,
    output logic [TAG_W-1:0] stn_tag,
    output logic             cls_err,
    output logic [CNT_W-1:0] cnt_rob,
    output logic [CNT_W-1:0] cnt_stn,
    output logic [CNT_W-1:0] cnt_ren
);
    localparam int N_CTR = 3;

    logic [N_STN-1:0] want;
    logic             bad;
    verdict_e         vd;
    logic [N_CTR-1:0] inc;
    logic [CNT_W-1:0] cnts [N_CTR];

    dsp_route u_route (
        .cls  (hd_cls),
        .want (want),
        .bad  (bad)
    );

    dsp_judge u_judge (
        .rob_full (rob_full),
        .want     (want),
        .stn_full (stn_full),
        .dst      (hd_dst),
        .ren_free (ren_free),
        .vd       (vd)
    );

    always_comb begin
        inc     = '0;
        adm_go  = 1'b0;
        stn_sel = '0;
        if (hd_valid) begin
            unique case (vd)
                VD_GO: begin
                    adm_go  = 1'b1;
                    stn_sel = want;
                end
                VD_ROB: inc[0] = 1'b1;
                VD_STN: inc[1] = 1'b1;
                VD_REN: inc[2] = 1'b1;
            endcase
        end
    end

    assign stn_tag = hd_tag;
    assign cls_err = hd_valid & bad;

    for (genvar g = 0; g < N_CTR; g++) begin : g_ctr
        dsp_stall_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc[g]),
            .cnt   (cnts[g])
        );
    end

    assign cnt_rob = cnts[0];
    assign cnt_stn = cnts[1];
    assign cnt_ren = cnts[2];
endmodule

// File: rtl/dsp_admit_chk.sv
module dsp_admit_chk #(
    parameter int TAG_W = 6,
    parameter int CNT_W = 16,
    parameter int N_STN = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hd_valid,
    input logic [2:0]       hd_cls,
    input logic             rob_full,
    input logic             adm_go,
    input logic [N_STN-1:0] stn_sel,
    input logic             cls_err,
    input logic [CNT_W-1:0] cnt_rob,
    input logic [CNT_W-1:0] cnt_stn,
    input logic [CNT_W-1:0] cnt_ren
);
    a_r2_rob_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_valid && rob_full) |-> !adm_go);

    a_r2_only_rob_counted: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_valid && rob_full) |=> ($stable(cnt_stn) && $stable(cnt_ren)));

    a_r9_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stn_sel));

    a_r9_no_sel_when_held: assert property (@(posedge clk) disable iff (!rst_n)
        !adm_go |-> (stn_sel == '0));

    a_r8_bad_no_station: assert property (@(posedge clk) disable iff (!rst_n)
        cls_err |-> (stn_sel == '0 && hd_cls == 3'd7));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hd_valid |=> ($stable(cnt_rob) && $stable(cnt_stn) && $stable(cnt_ren)));
endmodule

bind dsp_admit dsp_admit_chk #(.TAG_W(TAG_W), .CNT_W(CNT_W), .N_STN(dsp_pkg::N_STN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hd_valid (hd_valid),
    .hd_cls   (hd_cls),
    .rob_full (rob_full),
    .adm_go   (adm_go),
    .stn_sel  (stn_sel),
    .cls_err  (cls_err),
    .cnt_rob  (cnt_rob),
    .cnt_stn  (cnt_stn),
    .cnt_ren  (cnt_ren)
);

// File: tb/dsp_admit_bench.sv
module dsp_admit_bench;
    localparam int TAG_W = 5;
    localparam int CNT_W = 3;
    localparam int NS    = 5;
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hd_valid = 1'b0;
    logic [2:0]       hd_cls = '0;
    logic             hd_dst = 1'b0;
    logic [TAG_W-1:0] hd_tag = '0;
    logic             rob_full = 1'b0;
    logic [NS-1:0]    stn_full = '0;
    logic             ren_free = 1'b1;
    logic             adm_go;
    logic [NS-1:0]    stn_sel;
    logic [TAG_W-1:0] stn_tag;
    logic             cls_err;
    logic [CNT_W-1:0] cnt_rob, cnt_stn, cnt_ren;

    int checks = 0;
    int errors = 0;
    logic [CNT_W-1:0] m_rob = '0, m_stn = '0, m_ren = '0;

    always #5 clk = ~clk;

    dsp_admit #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_dsp_admit (
        .clk(clk), .rst_n(rst_n), .hd_valid(hd_valid), .hd_cls(hd_cls),
        .hd_dst(hd_dst), .hd_tag(hd_tag), .rob_full(rob_full),
        .stn_full(stn_full), .ren_free(ren_free), .adm_go(adm_go),
        .stn_sel(stn_sel), .stn_tag(stn_tag), .cls_err(cls_err),
        .cnt_rob(cnt_rob), .cnt_stn(cnt_stn), .cnt_ren(cnt_ren)
    );

    function automatic logic [NS-1:0] f_want(input logic [2:0] c);
        case (c)
            3'd0, 3'd1: return 5'b00001;
            3'd2:       return 5'b00010;
            3'd3:       return 5'b00100;
            3'd4:       return 5'b01000;
            3'd5:       return 5'b10000;
            default:    return 5'b00000;
        endcase
    endfunction

    // 0 go, 1 rob, 2 station, 3 rename
    function automatic int f_verdict(input logic rf, input logic [2:0] c,
                                     input logic [NS-1:0] sf, input logic d,
                                     input logic rn);
        if (rf) return 1;
        if (|(f_want(c) & sf)) return 2;
        if (d && !rn) return 3;
        return 0;
    endfunction

    function automatic logic [CNT_W-1:0] f_sat(input logic [CNT_W-1:0] v);
        return (v == TOP) ? v : v + 1'b1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at negedge, check outputs mid-cycle, model counters across the edge
    task automatic step(input logic v, input logic [2:0] c, input logic d,
                        input logic [TAG_W-1:0] t, input logic rf,
                        input logic [NS-1:0] sf, input logic rn, input string req);
        int vd;
        @(negedge clk);
        hd_valid = v; hd_cls = c; hd_dst = d; hd_tag = t;
        rob_full = rf; stn_full = sf; ren_free = rn;
        #1;
        vd = f_verdict(rf, c, sf, d, rn);
        chk({req, " R1 go"}, adm_go, v && vd == 0);
        chk({req, " R9 sel"}, stn_sel, (v && vd == 0) ? f_want(c) : 5'b0);
        chk("R9 tag", stn_tag, t);
        chk("R8 err", cls_err, v && c == 3'd7);
        if (v) begin
            if (vd == 1) m_rob = f_sat(m_rob);
            if (vd == 2) m_stn = f_sat(m_stn);
            if (vd == 3) m_ren = f_sat(m_ren);
        end
        @(posedge clk); #2;
        chk({req, " R2 cnt_rob"}, cnt_rob, m_rob);
        chk({req, " R3 cnt_stn"}, cnt_stn, m_stn);
        chk({req, " R4 cnt_ren"}, cnt_ren, m_ren);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #2;
        chk("R11 rob", cnt_rob, 0);
        chk("R11 stn", cnt_stn, 0);
        chk("R11 ren", cnt_ren, 0);
        rst_n = 1'b1;

        // directed corners
        step(1, 3'd1, 1, 5'h03, 1, 5'b11111, 0, "R2 rob wins");
        step(1, 3'd0, 1, 5'h04, 0, 5'b00001, 0, "R6 R3 logic->int stn");
        step(1, 3'd2, 1, 5'h05, 0, 5'b11101, 0, "R4 fp rename");
        step(1, 3'd3, 0, 5'h06, 0, 5'b11011, 0, "R5 no dst");
        step(1, 3'd6, 1, 5'h07, 0, 5'b11111, 1, "R7 nop");
        step(1, 3'd7, 1, 5'h08, 0, 5'b11111, 1, "R8 bad code");
        step(1, 3'd5, 1, 5'h09, 0, 5'b01111, 1, "R6 branch");
        step(1, 3'd4, 1, 5'h0a, 0, 5'b10111, 1, "R6 muldiv");
        step(0, 3'd1, 1, 5'h0b, 1, 5'b11111, 0, "R10 idle");
        for (int i = 0; i < 10; i++)
            step(1, 3'd2, 0, 5'h0c, 1, 5'b0, 1, "R10 rob saturate");
        chk("R10 rob top", cnt_rob, TOP);

        // constrained random
        for (int i = 0; i < 600; i++) begin
            logic [NS-1:0] sf;
            sf = NS'($urandom) & NS'($urandom);
            step(($urandom % 8) != 0, 3'($urandom), 1'($urandom),
                 TAG_W'($urandom), ($urandom % 4) == 0, sf,
                 ($urandom % 3) != 0, "RND");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule